// File: doc/BRIEF.md
# Ping-Pong Stream Buffer with Byte-Aligned Window Read

This block sits between a transfer engine and an 8×8 processing array. It holds two identical storage sets. At any moment one set is the compute set, which serves the array. The other is the transfer set, which the transfer engine fills or drains. A single toggle input swaps the two roles. An array kernel can therefore run on one set while fresh data streams into the other, and the swap happens without any copy.

Each set holds two banks, A and B, of 64 rows × 8 bytes. An array read chooses a row and a starting byte column. The block fetches that row and the row after it from both banks, joins each pair into 16 bytes, and passes each through a byte funnel. The funnel keeps the 8 consecutive bytes that begin at the column. The result is a 128-bit word that gives each of the eight cells in an array column one A byte and one B byte. Array results are written back as whole rows into bank A of the compute set. The transfer engine moves 64-bit rows in and out of either bank of the transfer set.

Top module: `dual_set_stream_buf`

## Requirements
- R1: After reset, set 0 is the compute set and act_set_o reads 0.
- R2: swap_i high at a clock edge inverts act_set_o at that edge. Every read or write sampled on that same edge still uses the roles that held before the swap.
- R3: A transfer write stores dma_wdata into row dma_wr_row of the transfer set, in bank A when dma_wr_bank is 0 and in bank B when it is 1. Byte j of a row occupies bits 8j+7:8j.
- R4: A transfer write never alters the data returned by array reads of the compute set, including a write in the same cycle as such a read.
- R5: An array read with row r and column c returns its data on arr_data in the next cycle. Take the 16 bytes formed by row r (bytes 0..7) followed by row r+1 (bytes 8..15). Lane k then carries joined byte c+k of bank A in bits 16k+7:16k and joined byte c+k of bank B in bits 16k+15:16k+8.
- R6: When r is 63, the following row is row 0.
- R7: Column 0 returns row r of each bank unshifted.
- R8: An array write stores arr_wdata into row arr_wr_row of bank A of the compute set. Bank B is left unchanged.
- R9: A transfer read of row dma_rd_row in bank dma_rd_bank (0 = A, 1 = B) of the transfer set returns that row on dma_rdata in the next cycle.
- R10: If an array read and an array write address the same row in the same cycle, the read returns the row's previous contents.
- R11: After a swap, data written into the former transfer set is visible to array reads, and rows written back into the former compute set are visible to transfer reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_i | input | 1 | Exchange compute and transfer roles at this edge |
| act_set_o | output | 1 | Index of the current compute set |
| dma_wr_en | input | 1 | Transfer write strobe |
| dma_wr_bank | input | 1 | Transfer write bank (0 = A, 1 = B) |
| dma_wr_row | input | 6 | Transfer write row |
| dma_wdata | input | 64 | Transfer write data |
| dma_rd_en | input | 1 | Transfer read strobe |
| dma_rd_bank | input | 1 | Transfer read bank (0 = A, 1 = B) |
| dma_rd_row | input | 6 | Transfer read row |
| dma_rdata | output | 64 | Transfer read data, one cycle after the request |
| arr_rd_en | input | 1 | Array window read strobe |
| arr_rd_row | input | 6 | Array read start row |
| arr_rd_col | input | 3 | Array read start byte column |
| arr_data | output | 128 | Interleaved A/B window, one cycle after the request |
| arr_wr_en | input | 1 | Array write-back strobe |
| arr_wr_row | input | 6 | Array write-back row |
| arr_wdata | input | 64 | Array write-back data (bank A) |

## Verification
The window read is exercised at column 0, at middle columns and at column 7. Column 0 shows whether the funnel passes a row through untouched. The middle columns show that the two fetched rows are joined in the right order and that the funnel shifts in the right direction. Column 7 shows that only one byte comes from the first row. Reads at rows 62 and 63 show whether the next-row address wraps to row 0 or runs past the end. Each bank and row gets a distinct byte pattern, so an A/B lane swap or an off-by-one row shows up as a miscompare. Some reads share a cycle with a transfer write, a write-back to the same row, or a swap. These reads show whether set isolation, read-before-write ordering and the timing of the role change are correct.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_SETS = 2;
  localparam int NUM_BANKS = 2;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/dsb_mem.sv
// One write port and two synchronous read ports; read-first on collision.
module dsb_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re0,
  input  logic [AW-1:0]    raddr0,
  output logic [WIDTH-1:0] rdata0,
  input  logic             re1,
  input  logic [AW-1:0]    raddr1,
  output logic [WIDTH-1:0] rdata1
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re0) rdata0 <= mem[raddr0];
  end

  always_ff @(posedge clk) begin
    if (re1) rdata1 <= mem[raddr1];
  end

  // R10: a read returns the contents from before any same-edge write
  a_r10_read_first: assert property (@(posedge clk) disable iff (rst)
    re0 |=> rdata0 == $past(mem[raddr0]));

  // R3: the written word is present at the written row
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dsb_align.sv
// Byte funnel: selects BYTES consecutive bytes out of {hi, lo} starting at col.
module dsb_align
  import dsb_pkg::*;
#(
  parameter int BYTES = 8,
  localparam int CW = $clog2(BYTES),
  localparam int DW = BYTES * BYTE_W
) (
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [CW-1:0] col,
  output logic [DW-1:0] win
);
  logic [2*DW-1:0] joined;
  logic [CW:0]     idx;

  assign joined = {hi, lo};

  always_comb begin
    idx = '0;
    for (int k = 0; k < BYTES; k++) begin
      idx = (CW+1)'(col) + (CW+1)'(k);
      win[k*BYTE_W +: BYTE_W] = joined[int'(idx)*BYTE_W +: BYTE_W];
    end
  end

  // R7: an unshifted window is exactly the first row
  always_comb begin
    if (col == '0) begin
      a_r7_col0_passthru: assert (win == lo);
    end
  end
endmodule

// File: rtl/dsb_set.sv
// One storage set: two banks, with ports steered by the set's current role.
module dsb_set
  import dsb_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int BYTES = 8,
  localparam int RW = $clog2(ROWS),
  localparam int DW = BYTES * BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_active,
  input  logic          arr_rd_en,
  input  logic [RW-1:0] arr_rd_row,
  input  logic          arr_wr_en,
  input  logic [RW-1:0] arr_wr_row,
  input  logic [DW-1:0] arr_wdata,
  input  logic          dma_wr_en,
  input  bank_e         dma_wr_bank,
  input  logic [RW-1:0] dma_wr_row,
  input  logic [DW-1:0] dma_wdata,
  input  logic          dma_rd_en,
  input  logic [RW-1:0] dma_rd_row,
  output logic [DW-1:0] cur_row [NUM_BANKS],
  output logic [DW-1:0] nxt_row_data [NUM_BANKS]
);
  logic [RW-1:0] nxt_row;
  logic          re0, re1;
  logic [RW-1:0] raddr0;

  assign nxt_row = (arr_rd_row == RW'(ROWS-1)) ? '0 : arr_rd_row + 1'b1;
  assign re0     = is_active ? arr_rd_en : dma_rd_en;
  assign raddr0  = is_active ? arr_rd_row : dma_rd_row;
  assign re1     = is_active & arr_rd_en;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bit IS_A = (b == 0);
    logic          we;
    logic [RW-1:0] waddr;
    logic [DW-1:0] wdata;

    always_comb begin
      if (is_active) begin
        we    = IS_A && arr_wr_en;
        waddr = arr_wr_row;
        wdata = arr_wdata;
      end else begin
        we    = dma_wr_en && (dma_wr_bank == bank_e'(b));
        waddr = dma_wr_row;
        wdata = dma_wdata;
      end
    end

    dsb_mem #(.DEPTH(ROWS), .WIDTH(DW)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .re0   (re0),
      .raddr0(raddr0),
      .rdata0(cur_row[b]),
      .re1   (re1),
      .raddr1(nxt_row),
      .rdata1(nxt_row_data[b])
    );
  end
endmodule

// File: rtl/dual_set_stream_buf.sv
module dual_set_stream_buf
  import dsb_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int BYTES = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(BYTES),
  localparam int DW = BYTES * BYTE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            swap_i,
  output logic            act_set_o,
  input  logic            dma_wr_en,
  input  logic            dma_wr_bank,
  input  logic [RW-1:0]   dma_wr_row,
  input  logic [DW-1:0]   dma_wdata,
  input  logic            dma_rd_en,
  input  logic            dma_rd_bank,
  input  logic [RW-1:0]   dma_rd_row,
  output logic [DW-1:0]   dma_rdata,
  input  logic            arr_rd_en,
  input  logic [RW-1:0]   arr_rd_row,
  input  logic [CW-1:0]   arr_rd_col,
  output logic [2*DW-1:0] arr_data,
  input  logic            arr_wr_en,
  input  logic [RW-1:0]   arr_wr_row,
  input  logic [DW-1:0]   arr_wdata
);
  logic          act_q;
  logic          rd_set_q;
  logic [CW-1:0] col_q;
  logic          dma_set_q;
  bank_e         dma_bank_q;

  logic [DW-1:0] cur_row [NUM_SETS][NUM_BANKS];
  logic [DW-1:0] nxt_row [NUM_SETS][NUM_BANKS];
  logic [DW-1:0] win_a, win_b;

  // Role register
  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else if (swap_i) act_q <= ~act_q;
  end
  assign act_set_o = act_q;

  // Request attributes carried alongside the memory read stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_set_q   <= 1'b0;
      col_q      <= '0;
      dma_set_q  <= 1'b1;
      dma_bank_q <= BANK_A;
    end else begin
      if (arr_rd_en) begin
        rd_set_q <= act_q;
        col_q    <= arr_rd_col;
      end
      if (dma_rd_en) begin
        dma_set_q  <= ~act_q;
        dma_bank_q <= bank_e'(dma_rd_bank);
      end
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    dsb_set #(.ROWS(ROWS), .BYTES(BYTES)) u_set (
      .clk         (clk),
      .rst         (rst),
      .is_active   (act_q == 1'(s)),
      .arr_rd_en   (arr_rd_en),
      .arr_rd_row  (arr_rd_row),
      .arr_wr_en   (arr_wr_en),
      .arr_wr_row  (arr_wr_row),
      .arr_wdata   (arr_wdata),
      .dma_wr_en   (dma_wr_en),
      .dma_wr_bank (bank_e'(dma_wr_bank)),
      .dma_wr_row  (dma_wr_row),
      .dma_wdata   (dma_wdata),
      .dma_rd_en   (dma_rd_en),
      .dma_rd_row  (dma_rd_row),
      .cur_row     (cur_row[s]),
      .nxt_row_data(nxt_row[s])
    );
  end

  dsb_align #(.BYTES(BYTES)) u_align_a (
    .lo (cur_row[rd_set_q][BANK_A]),
    .hi (nxt_row[rd_set_q][BANK_A]),
    .col(col_q),
    .win(win_a)
  );

  dsb_align #(.BYTES(BYTES)) u_align_b (
    .lo (cur_row[rd_set_q][BANK_B]),
    .hi (nxt_row[rd_set_q][BANK_B]),
    .col(col_q),
    .win(win_b)
  );

  // Lane k: A byte low, B byte high
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign arr_data[2*BYTE_W*k +: BYTE_W]          = win_a[BYTE_W*k +: BYTE_W];
    assign arr_data[2*BYTE_W*k + BYTE_W +: BYTE_W] = win_b[BYTE_W*k +: BYTE_W];
  end

  assign dma_rdata = cur_row[dma_set_q][dma_bank_q];

  // R2: a swap inverts the role at that edge
  a_r2_swap_flips: assert property (@(posedge clk) disable iff (rst)
    swap_i |=> act_set_o != $past(act_set_o));

  // R2: without a swap the role is held
  a_r2_role_held: assert property (@(posedge clk) disable iff (rst)
    !swap_i |=> $stable(act_set_o));

  // R9: a transfer read always targets the set that was not computing
  a_r9_dma_other_set: assert property (@(posedge clk) disable iff (rst)
    dma_rd_en |=> dma_set_q != $past(act_q));
endmodule

// File: tb/tb_dual_set_stream_buf.sv
`timescale 1ns/1ps
module tb_dual_set_stream_buf;
  localparam int ROWS = 64;
  localparam int BYTES = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         swap_i;
  logic         act_set_o;
  logic         dma_wr_en, dma_wr_bank;
  logic [5:0]   dma_wr_row;
  logic [63:0]  dma_wdata;
  logic         dma_rd_en, dma_rd_bank;
  logic [5:0]   dma_rd_row;
  logic [63:0]  dma_rdata;
  logic         arr_rd_en;
  logic [5:0]   arr_rd_row;
  logic [2:0]   arr_rd_col;
  logic [127:0] arr_data;
  logic         arr_wr_en;
  logic [5:0]   arr_wr_row;
  logic [63:0]  arr_wdata;

  int n_vec = 0;
  int n_bad = 0;
  logic tb_act;
  logic [63:0] mdl [2][2][ROWS];

  always #2 clk = ~clk;

  dual_set_stream_buf #(.ROWS(ROWS), .BYTES(BYTES)) dut (
    .clk(clk), .rst(rst), .swap_i(swap_i), .act_set_o(act_set_o),
    .dma_wr_en(dma_wr_en), .dma_wr_bank(dma_wr_bank), .dma_wr_row(dma_wr_row),
    .dma_wdata(dma_wdata), .dma_rd_en(dma_rd_en), .dma_rd_bank(dma_rd_bank),
    .dma_rd_row(dma_rd_row), .dma_rdata(dma_rdata), .arr_rd_en(arr_rd_en),
    .arr_rd_row(arr_rd_row), .arr_rd_col(arr_rd_col), .arr_data(arr_data),
    .arr_wr_en(arr_wr_en), .arr_wr_row(arr_wr_row), .arr_wdata(arr_wdata)
  );

  function automatic logic [63:0] pat(int s, int b, int r);
    logic [63:0] v;
    for (int j = 0; j < 8; j++)
      v[8*j +: 8] = 8'(r*3 + j*37) ^ (s != 0 ? 8'h5A : 8'h00) ^ (b != 0 ? 8'hC3 : 8'h00);
    return v;
  endfunction

  function automatic logic [127:0] exp_win(int s, int r, int c);
    logic [127:0] v;
    for (int k = 0; k < 8; k++) begin
      int idx = c + k;
      int rr  = (idx < 8) ? r : (r + 1) % ROWS;
      int by  = idx % 8;
      v[16*k +: 8]     = mdl[s][0][rr][8*by +: 8];
      v[16*k + 8 +: 8] = mdl[s][1][rr][8*by +: 8];
    end
    return v;
  endfunction

  task automatic chk(logic [127:0] act, logic [127:0] exp, string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    swap_i = 0; dma_wr_en = 0; dma_wr_bank = 0; dma_wr_row = 0; dma_wdata = 0;
    dma_rd_en = 0; dma_rd_bank = 0; dma_rd_row = 0;
    arr_rd_en = 0; arr_rd_row = 0; arr_rd_col = 0;
    arr_wr_en = 0; arr_wr_row = 0; arr_wdata = 0;
  endtask

  task automatic dma_write(int b, int r, logic [63:0] d);
    dma_wr_en = 1; dma_wr_bank = 1'(b); dma_wr_row = 6'(r); dma_wdata = d;
    @(negedge clk);
    dma_wr_en = 0;
    mdl[~tb_act][b][r] = d;
  endtask

  task automatic arr_read_check(int r, int c, string tag);
    arr_rd_en = 1; arr_rd_row = 6'(r); arr_rd_col = 3'(c);
    @(negedge clk);
    arr_rd_en = 0;
    chk(arr_data, exp_win(tb_act, r, c), tag);
  endtask

  task automatic dma_read_check(int b, int r, string tag);
    dma_rd_en = 1; dma_rd_bank = 1'(b); dma_rd_row = 6'(r);
    @(negedge clk);
    dma_rd_en = 0;
    chk({64'h0, dma_rdata}, {64'h0, mdl[~tb_act][b][r]}, tag);
  endtask

  task automatic do_swap(string tag);
    swap_i = 1;
    @(negedge clk);
    swap_i = 0;
    tb_act = ~tb_act;
    chk({127'h0, act_set_o}, {127'h0, tb_act}, tag);
  endtask

  // R1
  task automatic t_reset();
    rst = 1; idle_inputs();
    repeat (3) @(negedge clk);
    chk({127'h0, act_set_o}, 128'h0, "R1 reset compute set");
    rst = 0;
    tb_act = 0;
    @(negedge clk);
    chk({127'h0, act_set_o}, 128'h0, "R1 after release");
  endtask

  // R3, R9: load and read back the transfer set
  task automatic t_fill(string tag);
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < 2; b++)
        dma_write(b, r, pat(~tb_act, b, r));
    dma_read_check(0, 0, {tag, " R9 bank A row 0"});
    dma_read_check(1, 17, {tag, " R9 bank B row 17"});
    dma_read_check(0, 63, {tag, " R3 bank A row 63"});
  endtask

  // R5, R6, R7: window reads at many alignments
  task automatic t_windows();
    arr_read_check(0, 0, "R7 row 0 col 0");
    arr_read_check(40, 0, "R7 row 40 col 0");
    arr_read_check(3, 5, "R5 row 3 col 5");
    arr_read_check(20, 7, "R5 row 20 col 7");
    arr_read_check(11, 1, "R5 row 11 col 1");
    arr_read_check(62, 7, "R5 row 62 col 7");
    arr_read_check(63, 4, "R6 row 63 col 4 wrap");
    arr_read_check(63, 1, "R6 row 63 col 1 wrap");
  endtask

  // R4: transfer write to the same row during an array read
  task automatic t_isolation();
    logic [127:0] e;
    e = exp_win(tb_act, 10, 3);
    dma_wr_en = 1; dma_wr_bank = 0; dma_wr_row = 6'd10; dma_wdata = 64'hDEAD_BEEF_0BAD_F00D;
    arr_rd_en = 1; arr_rd_row = 6'd10; arr_rd_col = 3'd3;
    @(negedge clk);
    dma_wr_en = 0; arr_rd_en = 0;
    mdl[~tb_act][0][10] = 64'hDEAD_BEEF_0BAD_F00D;
    chk(arr_data, e, "R4 concurrent transfer write");
    arr_read_check(10, 3, "R4 compute set after transfer write");
    dma_read_check(0, 10, "R3 transfer write landed");
  endtask

  // R10, R8: write-back and read of the same row in one cycle
  task automatic t_writeback();
    logic [127:0] e;
    e = exp_win(tb_act, 30, 0);
    arr_rd_en = 1; arr_rd_row = 6'd30; arr_rd_col = 3'd0;
    arr_wr_en = 1; arr_wr_row = 6'd30; arr_wdata = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    arr_rd_en = 0; arr_wr_en = 0;
    chk(arr_data, e, "R10 read-first on collision");
    mdl[tb_act][0][30] = 64'h0123_4567_89AB_CDEF;
    arr_read_check(30, 0, "R8 write-back in bank A, bank B kept");
    arr_read_check(29, 6, "R8 write-back seen as next row");
  endtask

  // R2, R11: swap on the same edge as a write and a read
  task automatic t_swap_edge();
    logic [127:0] e;
    e = exp_win(tb_act, 5, 2);
    swap_i = 1;
    dma_wr_en = 1; dma_wr_bank = 1; dma_wr_row = 6'd5; dma_wdata = 64'hA5A5_5A5A_F0F0_0F0F;
    arr_rd_en = 1; arr_rd_row = 6'd5; arr_rd_col = 3'd2;
    @(negedge clk);
    swap_i = 0; dma_wr_en = 0; arr_rd_en = 0;
    chk(arr_data, e, "R2 read on swap edge uses old compute set");
    mdl[~tb_act][1][5] = 64'hA5A5_5A5A_F0F0_0F0F;
    tb_act = ~tb_act;
    chk({127'h0, act_set_o}, {127'h0, tb_act}, "R2 role flipped");
    arr_read_check(5, 0, "R11 swapped-in data visible to array");
    arr_read_check(4, 4, "R11 swapped-in data as next row");
    dma_read_check(0, 30, "R11 write-back visible to transfer side");
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1;
    idle_inputs();
    @(negedge clk);
    t_reset();
    t_fill("set1");
    do_swap("R11 first swap");
    t_fill("set0");
    t_windows();
    t_isolation();
    t_writeback();
    t_swap_edge();
    t_windows();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule